// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block moves 36-bit words from a write port clocked by `clk_a` to a read port clocked by `clk_b`. The two clocks are free-running and may be unrelated or the same clock. Storage is `2**ADDR_W` words: 256 by default, and 1,024 when `ADDR_W` is 10. Each pointer is kept in binary and in Gray code. The Gray copy crosses into the other domain through two flops. Full and almost-full are worked out on the write side. Empty, output-ready and almost-empty are worked out on the read side.

Two settings are sampled while the full reset is held: the flag style and the source of the almost-flag offset. In standard style, `rd_stat` is an empty flag, `wr_stat` is a full flag, and a read request loads the word into `rd_data` one `clk_b` cycle later. In fall-through style, `rd_stat` means a word is already waiting on `rd_data`, and `wr_stat` means a write will be accepted. The almost-empty and almost-full flags share one offset. The offset is 8, 16 or 64, or it is programmed after reset, either as a single word written through the write port or as bits shifted in one per `clk_a` cycle. A partial reset empties the FIFO and keeps the flag style and the offset.

Write-side states: `W_PAR_LOAD` (waiting for the offset word) goes to `W_RUN` on the first write. `W_SER_LOAD` (shifting the offset in) goes to `W_RUN` after `ADDR_W` serial bits. `W_RUN` is normal operation. Read-side states: `R_STD` is standard style. `R_FW_EMPTY` goes to `R_FW_VALID` as soon as the memory holds a word. `R_FW_VALID` goes back to `R_FW_EMPTY` when the waiting word is read and the memory is empty. A full reset places each side in the state its settings select. A partial reset keeps the write-side state.

Top module: `xclk_flag_fifo`

## Requirements
- R1: Words leave the read port in the order they were written, with their value unchanged, for any mix of write and read activity on the two clocks.
- R2: In standard style (`cfg_fwft`=0 at full reset), `rd_stat`=1 means the FIFO is empty. A read request while `rd_stat`=0 places the oldest word on `rd_data` at the next `clk_b` rising edge. `rd_data` holds its value otherwise.
- R3: In fall-through style (`cfg_fwft`=1), the oldest word appears on `rd_data` with `rd_stat`=1 without any read request. A read while `rd_stat`=1 consumes that word and presents the next one. `rd_data` holds its value while no read is made.
- R4: In standard style the FIFO holds exactly `2**ADDR_W` words, and `wr_stat`=1 (full) once it holds that many. A write while full stores nothing and moves no pointer.
- R5: A read while the FIFO is empty returns no word, leaves `rd_data` unchanged and moves no pointer.
- R6: At full reset, `cfg_offset_sel` 00, 01 and 10 set the shared offset to 8, 16 and 64.
- R7: `almost_empty`=1 exactly when the words held, including a word waiting on `rd_data` in fall-through style, are at most the offset.
- R8: `almost_full`=1 exactly when the free memory slots are at most the offset.
- R9: With `cfg_offset_sel`=11 and `cfg_serial`=0, the first write after full reset loads the offset from `wr_data[ADDR_W-1:0]` and is not stored. Until that write, the FIFO shows full (standard style) or not ready (fall-through style).
- R10: With `cfg_offset_sel`=11 and `cfg_serial`=1, the offset is shifted in most significant bit first from `ser_bit` on each `clk_a` edge where `ser_en`=1, for `ADDR_W` bits. Writes before the last bit are ignored.
- R11: A partial reset (`rst_part_n`=0) empties the FIFO and keeps the flag style and the offset, including a programmed offset.
- R12: A full reset (`rst_full_n`=0) empties the FIFO and takes the flag style and the offset source anew from the setting pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_full_n | input | 1 | Full reset, active low; samples the setting pins |
| rst_part_n | input | 1 | Partial reset, active low; keeps the settings |
| cfg_fwft | input | 1 | 1 selects fall-through style, sampled during full reset |
| cfg_offset_sel | input | 2 | Offset source: 00=8, 01=16, 10=64, 11=programmed |
| cfg_serial | input | 1 | With source 11: 1 serial load, 0 load by write |
| ser_en | input | 1 | Serial offset bit valid |
| ser_bit | input | 1 | Serial offset bit, most significant first |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write word, or the offset word during a load by write |
| wr_stat | output | 1 | Full flag (standard) or input-ready flag (fall-through) |
| almost_full | output | 1 | Free slots at most the offset |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read word register |
| rd_stat | output | 1 | Empty flag (standard) or output-ready flag (fall-through) |
| almost_empty | output | 1 | Words held at most the offset |

## Verification
The assertions rely on the settings changing only while the full reset is held, and on both resets being held for several cycles of each clock, so that each domain sees the reset. They also rely on the offset changing only during its load, before data flows. The stimulus meets these conditions: it changes setting pins only around a reset held for four edges of both clocks, and it programs the offset before it writes any data. The random traffic is drawn from a fixed seed. Writes are made only while the flag says a write will be accepted and reads only while it says data is present, and the directed cases add deliberate writes while full and reads while empty.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    typedef enum logic [1:0] {
        W_PAR_LOAD = 2'd0,
        W_SER_LOAD = 2'd1,
        W_RUN      = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        R_STD      = 2'd0,
        R_FW_EMPTY = 2'd1,
        R_FW_VALID = 2'd2
    } rd_state_e;

    localparam logic [1:0] SEL_PROG = 2'b11;

    // Preset offsets chosen by the source select; 11 means programmed (starts at zero).
    function automatic logic [6:0] preset_offset(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 7'd8;
            2'b01:   return 7'd16;
            2'b10:   return 7'd64;
            default: return 7'd0;
        endcase
    endfunction

endpackage

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // The read side registers this value itself when it pops a word.
    assign q = mem[raddr];
endmodule

// File: rtl/xfifo_ptr_sync.sv
module xfifo_ptr_sync #(
    parameter int PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] gray_i,
    output logic [PTR_W-1:0] bin_o
);
    logic [PTR_W-1:0] meta_q;
    logic [PTR_W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_i;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the parity of itself and every bit above it.
    for (genvar i = 0; i < PTR_W; i++) begin : g_g2b
        assign bin_o[i] = ^sync_q[PTR_W-1:i];
    end
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
    import xfifo_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_a,
    input  logic              rst_full_n,
    input  logic              rst_part_n,
    input  logic              cfg_fwft,
    input  logic [1:0]        cfg_offset_sel,
    input  logic              cfg_serial,
    input  logic              ser_en,
    input  logic              ser_bit,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] prog_word,
    input  logic [ADDR_W:0]   rsync_bin,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              mem_full,
    output logic              wr_run,
    output logic              almost_full,
    output logic              fwft_q,
    output logic [ADDR_W-1:0] offset_q
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

    wr_state_e         state_q, state_d;
    logic [PTR_W-1:0]  wbin_q, wbin_nx, occ, free_slots;
    logic [CNT_W-1:0]  cnt_q;
    logic              do_write, load_par, shift_bit;

    assign wbin_nx    = wbin_q + 1'b1;
    assign occ        = wbin_q - rsync_bin;
    assign free_slots = DEPTH_P - occ;

    // Next state and the actions taken in each state.
    always_comb begin
        state_d   = state_q;
        do_write  = 1'b0;
        load_par  = 1'b0;
        shift_bit = 1'b0;
        unique case (state_q)
            W_RUN: begin
                do_write = wr_en && !mem_full;
            end
            W_PAR_LOAD: begin
                if (wr_en) begin
                    load_par = 1'b1;
                    state_d  = W_RUN;
                end
            end
            W_SER_LOAD: begin
                if (ser_en) begin
                    shift_bit = 1'b1;
                    if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                        state_d = W_RUN;
                    end
                end
            end
            default: state_d = W_RUN;
        endcase
    end

    // State register: a full reset picks the state from the pins, a partial reset keeps it.
    always_ff @(posedge clk_a) begin
        if (!rst_full_n) begin
            if (cfg_offset_sel == SEL_PROG) begin
                state_q <= cfg_serial ? W_SER_LOAD : W_PAR_LOAD;
            end else begin
                state_q <= W_RUN;
            end
        end else if (rst_part_n) begin
            state_q <= state_d;
        end
    end

    // Configuration, offset and write pointer.
    always_ff @(posedge clk_a) begin
        if (!rst_full_n) begin
            fwft_q   <= cfg_fwft;
            offset_q <= ADDR_W'(preset_offset(cfg_offset_sel));
            cnt_q    <= '0;
            wbin_q   <= '0;
            wr_gray  <= '0;
        end else if (!rst_part_n) begin
            wbin_q   <= '0;
            wr_gray  <= '0;
        end else begin
            if (load_par) begin
                offset_q <= prog_word;
            end
            if (shift_bit) begin
                offset_q <= {offset_q[ADDR_W-2:0], ser_bit};
                cnt_q    <= cnt_q + 1'b1;
            end
            if (do_write) begin
                wbin_q  <= wbin_nx;
                wr_gray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end

    // Outputs.
    always_comb begin
        mem_full    = (occ == DEPTH_P);
        wr_run      = (state_q == W_RUN);
        almost_full = (free_slots <= {1'b0, offset_q});
        ram_we      = do_write;
        ram_waddr   = wbin_q[ADDR_W-1:0];
    end
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl
    import xfifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8
) (
    input  logic              clk_b,
    input  logic              rst,
    input  logic              fwft_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [ADDR_W:0]   wsync_bin,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] ram_q,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic [ADDR_W:0]   rd_gray,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_empty,
    output logic              fw_valid,
    output logic              almost_empty
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int OCC_W = ADDR_W + 2;

    rd_state_e        state_q, state_d;
    logic [PTR_W-1:0] rbin_q, rbin_nx;
    logic [OCC_W-1:0] occ;
    logic             pop;

    assign rbin_nx   = rbin_q + 1'b1;
    assign mem_empty = (rbin_q == wsync_bin);

    // Next state and pop decision.
    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        unique case (state_q)
            R_STD: begin
                pop = rd_en && !mem_empty;
            end
            R_FW_EMPTY: begin
                if (!mem_empty) begin
                    pop     = 1'b1;
                    state_d = R_FW_VALID;
                end
            end
            R_FW_VALID: begin
                if (rd_en) begin
                    pop = !mem_empty;
                    if (mem_empty) begin
                        state_d = R_FW_EMPTY;
                    end
                end
            end
            default: state_d = R_STD;
        endcase
    end

    always_ff @(posedge clk_b) begin
        if (rst) begin
            state_q <= fwft_i ? R_FW_EMPTY : R_STD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_b) begin
        if (rst) begin
            rbin_q  <= '0;
            rd_gray <= '0;
            rd_data <= '0;
        end else if (pop) begin
            rbin_q  <= rbin_nx;
            rd_gray <= rbin_nx ^ (rbin_nx >> 1);
            rd_data <= ram_q;
        end
    end

    // Outputs.
    always_comb begin
        ram_raddr    = rbin_q[ADDR_W-1:0];
        fw_valid     = (state_q == R_FW_VALID);
        occ          = OCC_W'(wsync_bin - rbin_q) + OCC_W'(fw_valid);
        almost_empty = (occ <= OCC_W'(offset_i));
    end
endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_full_n,
    input  logic              rst_part_n,
    input  logic              cfg_fwft,
    input  logic [1:0]        cfg_offset_sel,
    input  logic              cfg_serial,
    input  logic              ser_en,
    input  logic              ser_bit,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_stat,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_stat,
    output logic              almost_empty
);
    localparam int PTR_W = ADDR_W + 1;

    logic              w_rst, r_rst;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr, ram_raddr, offset_q;
    logic [DATA_W-1:0] ram_q;
    logic [PTR_W-1:0]  wr_gray, rd_gray, rsync_bin, wsync_bin;
    logic              mem_full, mem_empty, wr_run, fw_valid, fwft_q;

    assign w_rst = !rst_full_n || !rst_part_n;
    assign r_rst = !rst_full_n || !rst_part_n;

    xfifo_wr_ctl #(.ADDR_W(ADDR_W)) i_wr_ctl (
        .clk_a          (clk_a),
        .rst_full_n     (rst_full_n),
        .rst_part_n     (rst_part_n),
        .cfg_fwft       (cfg_fwft),
        .cfg_offset_sel (cfg_offset_sel),
        .cfg_serial     (cfg_serial),
        .ser_en         (ser_en),
        .ser_bit        (ser_bit),
        .wr_en          (wr_en),
        .prog_word      (wr_data[ADDR_W-1:0]),
        .rsync_bin      (rsync_bin),
        .ram_we         (ram_we),
        .ram_waddr      (ram_waddr),
        .wr_gray        (wr_gray),
        .mem_full       (mem_full),
        .wr_run         (wr_run),
        .almost_full    (almost_full),
        .fwft_q         (fwft_q),
        .offset_q       (offset_q)
    );

    xfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ram (
        .clk   (clk_a),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_data),
        .raddr (ram_raddr),
        .q     (ram_q)
    );

    xfifo_ptr_sync #(.PTR_W(PTR_W)) i_sync_w2r (
        .clk    (clk_b),
        .rst    (r_rst),
        .gray_i (wr_gray),
        .bin_o  (wsync_bin)
    );

    xfifo_ptr_sync #(.PTR_W(PTR_W)) i_sync_r2w (
        .clk    (clk_a),
        .rst    (w_rst),
        .gray_i (rd_gray),
        .bin_o  (rsync_bin)
    );

    xfifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd_ctl (
        .clk_b        (clk_b),
        .rst          (r_rst),
        .fwft_i       (fwft_q),
        .offset_i     (offset_q),
        .wsync_bin    (wsync_bin),
        .rd_en        (rd_en),
        .ram_q        (ram_q),
        .ram_raddr    (ram_raddr),
        .rd_gray      (rd_gray),
        .rd_data      (rd_data),
        .mem_empty    (mem_empty),
        .fw_valid     (fw_valid),
        .almost_empty (almost_empty)
    );

    // Flag meaning follows the style captured at full reset.
    assign wr_stat = fwft_q ? (wr_run && !mem_full) : (!wr_run || mem_full);
    assign rd_stat = fwft_q ? fw_valid : mem_empty;
endmodule

// File: rtl/xclk_flag_fifo_chk.sv
module xclk_flag_fifo_chk #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              w_rst,
    input logic              r_rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W:0]   wr_gray,
    input logic [ADDR_W:0]   rd_gray,
    input logic              mem_full,
    input logic              mem_empty,
    input logic              almost_full,
    input logic              fw_valid,
    input logic              fwft_q,
    input logic [DATA_W-1:0] rd_data
);
    assert_no_overflow_R4: assert property (@(posedge clk_a) disable iff (w_rst)
        (wr_en && mem_full) |=> $stable(wr_gray));

    assert_no_underflow_R5: assert property (@(posedge clk_b) disable iff (r_rst)
        mem_empty |=> $stable(rd_gray));

    assert_wr_gray_step_R1: assert property (@(posedge clk_a) disable iff (w_rst)
        $onehot0(wr_gray ^ $past(wr_gray)));

    assert_rd_gray_step_R1: assert property (@(posedge clk_b) disable iff (r_rst)
        $onehot0(rd_gray ^ $past(rd_gray)));

    assert_full_implies_af_R8: assert property (@(posedge clk_a) disable iff (w_rst)
        mem_full |-> almost_full);

    assert_fall_through_hold_R3: assert property (@(posedge clk_b) disable iff (r_rst)
        (fwft_q && fw_valid && !rd_en) |=> (fw_valid && $stable(rd_data)));

    assert_std_hold_R2: assert property (@(posedge clk_b) disable iff (r_rst)
        (!fwft_q && !(rd_en && !mem_empty)) |=> $stable(rd_data));
endmodule

bind xclk_flag_fifo xclk_flag_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk_a       (clk_a),
    .clk_b       (clk_b),
    .w_rst       (w_rst),
    .r_rst       (r_rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wr_gray     (wr_gray),
    .rd_gray     (rd_gray),
    .mem_full    (mem_full),
    .mem_empty   (mem_empty),
    .almost_full (almost_full),
    .fw_valid    (fw_valid),
    .fwft_q      (fwft_q),
    .rd_data     (rd_data)
);

// File: tb/test_xclk_flag_fifo.sv
`timescale 1ns/100ps
module test_xclk_flag_fifo;
    localparam int DW = 36;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_full_n = 1'b0, rst_part_n = 1'b1;
    logic cfg_fwft = 1'b0, cfg_serial = 1'b0;
    logic [1:0] cfg_offset_sel = 2'b00;
    logic ser_en = 1'b0, ser_bit = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic wr_stat, rd_stat, almost_full, almost_empty;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] q [$];
    logic [DW-1:0] got_w;

    always #4 clk_a = ~clk_a;
    initial begin
        #1.5;
        forever #5 clk_b = ~clk_b;
    end

    xclk_flag_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_xclk_flag_fifo (
        .clk_a(clk_a), .clk_b(clk_b), .rst_full_n(rst_full_n), .rst_part_n(rst_part_n),
        .cfg_fwft(cfg_fwft), .cfg_offset_sel(cfg_offset_sel), .cfg_serial(cfg_serial),
        .ser_en(ser_en), .ser_bit(ser_bit), .wr_en(wr_en), .wr_data(wr_data),
        .wr_stat(wr_stat), .almost_full(almost_full), .rd_en(rd_en), .rd_data(rd_data),
        .rd_stat(rd_stat), .almost_empty(almost_empty)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk_a);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    task automatic do_reset(input bit full, input bit fwft, input logic [1:0] sel, input bit ser);
        @(negedge clk_a);
        cfg_fwft = fwft; cfg_offset_sel = sel; cfg_serial = ser;
        if (full) rst_full_n = 1'b0; else rst_part_n = 1'b0;
        repeat (4) @(negedge clk_a);
        repeat (4) @(negedge clk_b);
        @(negedge clk_a);
        rst_full_n = 1'b1; rst_part_n = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk_a);
        repeat (6) @(negedge clk_b);
    endtask

    task automatic wr_burst(input int n, input logic [DW-1:0] base);
        @(negedge clk_a);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1; wr_data = base + DW'(i);
            @(negedge clk_a);
        end
        wr_en = 1'b0;
    endtask

    task automatic rd_one(output logic [DW-1:0] d);
        @(negedge clk_b) rd_en = 1'b1;
        @(negedge clk_b) rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic ser_load(input logic [AW-1:0] v);
        for (int i = AW - 1; i >= 0; i--) begin
            @(negedge clk_a) ser_en = 1'b1; ser_bit = v[i];
        end
        @(negedge clk_a) ser_en = 1'b0;
    endtask

    task automatic random_run(input bit fwft, input int n);
        q.delete();
        fork
            begin : writer
                int sent = 0;
                while (sent < n) begin
                    @(negedge clk_a);
                    if ((fwft ? wr_stat : !wr_stat) && ($urandom % 2 == 0)) begin
                        wr_en = 1'b1; wr_data = {4'($urandom), $urandom};
                        q.push_back(wr_data);
                        sent++;
                    end else wr_en = 1'b0;
                end
                @(negedge clk_a) wr_en = 1'b0;
            end
            begin : reader
                int got = 0;
                bit pend = 0;
                logic [DW-1:0] exp_w = '0;
                while (got < n) begin
                    @(negedge clk_b);
                    rd_en = 1'b0;
                    if (!fwft) begin
                        if (pend) begin
                            chk("R1 random std order", rd_data, exp_w);
                            got++; pend = 0;
                        end
                        if (got < n && !rd_stat && ($urandom % 3 != 0)) begin
                            rd_en = 1'b1; exp_w = q.pop_front(); pend = 1;
                        end
                    end else if (rd_stat && ($urandom % 3 != 0)) begin
                        chk("R1 R3 random fall-through order", rd_data, q.pop_front());
                        rd_en = 1'b1; got++;
                    end
                end
                @(negedge clk_b) rd_en = 1'b0;
            end
        join
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // Reset state, standard style, offset 8
        do_reset(1, 0, 2'b00, 0);
        settle();
        chk("R2 empty after reset", rd_stat, 1);
        chk("R4 not full after reset", wr_stat, 0);
        chk("R7 almost_empty after reset", almost_empty, 1);
        chk("R8 almost_full after reset", almost_full, 0);

        // R6 R7: offset 8 boundary
        wr_burst(8, 36'd100);
        settle();
        chk("R6 R7 occupancy 8 with offset 8", almost_empty, 1);
        wr_burst(1, 36'd108);
        settle();
        chk("R7 occupancy 9 with offset 8", almost_empty, 0);
        chk("R2 not empty", rd_stat, 0);
        for (int i = 0; i < 9; i++) begin
            rd_one(got_w);
            chk("R1 R2 read order", got_w, 36'd100 + DW'(i));
        end
        settle();
        chk("R2 empty after drain", rd_stat, 1);

        // R5: read while empty
        @(negedge clk_b) rd_en = 1'b1;
        @(negedge clk_b) rd_en = 1'b0;
        chk("R5 rd_data unchanged on empty read", rd_data, 36'd108);
        chk("R5 still empty", rd_stat, 1);
        wr_burst(1, 36'h200);
        settle();
        rd_one(got_w);
        chk("R5 next word after empty read", got_w, 36'h200);

        // R4 R8: fill to capacity
        wr_burst(DEPTH - 9, 36'h1000);
        settle();
        chk("R8 free 9 with offset 8", almost_full, 0);
        wr_burst(1, 36'h1000 + DW'(DEPTH - 9));
        settle();
        chk("R8 free 8 with offset 8", almost_full, 1);
        wr_burst(8, 36'h1000 + DW'(DEPTH - 8));
        settle();
        chk("R4 full at capacity", wr_stat, 1);
        wr_burst(1, 36'hBAD);
        settle();
        chk("R4 still full after extra write", wr_stat, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd_one(got_w);
            chk("R4 R1 full drain order", got_w, 36'h1000 + DW'(i));
        end
        settle();
        chk("R4 extra write not stored", rd_stat, 1);
        chk("R4 not full after drain", wr_stat, 0);

        // R6: offsets 16 and 64
        do_reset(1, 0, 2'b01, 0);
        wr_burst(16, 36'd0);
        settle();
        chk("R6 offset 16 at 16", almost_empty, 1);
        wr_burst(1, 36'd16);
        settle();
        chk("R6 offset 16 at 17", almost_empty, 0);
        do_reset(1, 0, 2'b10, 0);
        settle();
        chk("R12 full reset empties", rd_stat, 1);
        wr_burst(64, 36'd0);
        settle();
        chk("R6 offset 64 at 64", almost_empty, 1);
        wr_burst(1, 36'd64);
        settle();
        chk("R6 offset 64 at 65", almost_empty, 0);

        // R9: load offset by write
        do_reset(1, 0, 2'b11, 0);
        settle();
        chk("R9 shows full before load", wr_stat, 1);
        wr_burst(1, 36'd5);
        settle();
        chk("R9 ready after load", wr_stat, 0);
        chk("R9 load word not stored", rd_stat, 1);
        wr_burst(5, 36'h50);
        settle();
        chk("R9 offset 5 at 5", almost_empty, 1);
        wr_burst(1, 36'h55);
        settle();
        chk("R9 offset 5 at 6", almost_empty, 0);

        // R10: serial load of 3
        do_reset(1, 0, 2'b11, 1);
        wr_burst(1, 36'd77);
        ser_load(8'd3);
        settle();
        chk("R10 write during load ignored", rd_stat, 1);
        chk("R10 ready after load", wr_stat, 0);
        wr_burst(3, 36'h300);
        settle();
        chk("R10 offset 3 at 3", almost_empty, 1);
        wr_burst(1, 36'h303);
        settle();
        chk("R10 offset 3 at 4", almost_empty, 0);
        rd_one(got_w);
        chk("R10 first stored word", got_w, 36'h300);

        // R11: partial reset keeps offset 3 though pins now say 8
        do_reset(0, 1, 2'b00, 0);
        settle();
        chk("R11 partial reset empties", rd_stat, 1);
        chk("R11 style kept standard", wr_stat, 0);
        wr_burst(3, 36'h400);
        settle();
        chk("R11 kept offset at 3", almost_empty, 1);
        wr_burst(1, 36'h403);
        settle();
        chk("R11 kept offset at 4", almost_empty, 0);

        // R12: full reset takes pins anew
        do_reset(1, 0, 2'b00, 0);
        wr_burst(8, 36'h500);
        settle();
        chk("R12 offset 8 restored at 8", almost_empty, 1);
        wr_burst(1, 36'h508);
        settle();
        chk("R12 offset 8 restored at 9", almost_empty, 0);

        // R3: fall-through style
        do_reset(1, 1, 2'b00, 0);
        settle();
        chk("R3 not ready after reset", rd_stat, 0);
        chk("R3 input ready after reset", wr_stat, 1);
        wr_burst(1, 36'hABC);
        settle();
        chk("R3 word presented without read", rd_stat, 1);
        chk("R3 head value", rd_data, 36'hABC);
        wr_burst(1, 36'hDEF);
        settle();
        chk("R3 head held without read", rd_data, 36'hABC);
        rd_one(got_w);
        chk("R3 next word after read", got_w, 36'hDEF);
        chk("R3 still ready", rd_stat, 1);
        rd_one(got_w);
        settle();
        chk("R3 not ready after last read", rd_stat, 0);
        wr_burst(8, 36'h600);
        settle();
        chk("R7 fall-through occupancy 8", almost_empty, 1);
        wr_burst(1, 36'h608);
        settle();
        chk("R7 fall-through occupancy 9", almost_empty, 0);
        do_reset(0, 0, 2'b00, 0);
        settle();
        chk("R11 partial reset keeps fall-through", wr_stat, 1);
        chk("R11 partial reset empties fall-through", rd_stat, 0);

        // R1: random traffic in both styles
        random_run(1, 300);
        do_reset(1, 0, 2'b00, 0);
        random_run(0, 300);

        finish_run();
    end
endmodule